// File: doc/BRIEF.md
# DRAM Refresh and Power-Up Sequencer

This block sits beside a DRAM access controller and owns the memory's refresh and start-up obligations. After reset it keeps the strobes idle for a fixed power-up pause. It then runs a burst of CAS-before-RAS (CBR) refresh cycles to wake the array, and only after that burst does it report the memory as usable. From then on an interval timer requests one CBR refresh per row-retention slice. The slice is chosen so that every row is covered within the retention period.

The sequencer shares the strobe pins with the access controller through a level request/grant handshake. When a refresh is due it raises `rfsh_req` and holds it until `rfsh_gnt` is returned. While granted, it drives the CBR strobe pattern itself: CAS falls first, RAS follows, and both are released after the RAS-active time, followed by a RAS precharge. Because it uses CBR cycles only, the address bus is never used and the data pins remain in the high-impedance state. Missed intervals are counted up to a postpone limit. One interval beyond that limit is treated as a broken retention deadline: the ready output drops, a miss flag rises, and the full wake-up burst is run again.

Top module: `dram_refresh_sequencer`

## Requirements
- R1: While reset is held and in the first cycle after it, `init_ready` and `rfsh_req` are low and both `mem_ras_n` and `mem_cas_n` are high.
- R2: For exactly PAUSE_CYC clock edges after reset release, `rfsh_req` stays low and neither strobe moves; `rfsh_req` rises on edge PAUSE_CYC.
- R3: The strobes start a cycle only while `rfsh_gnt` is high. A raised `rfsh_req` stays high, with the strobes idle, for as long as the grant is withheld.
- R4: The wake-up phase consists of exactly WAKE_CNT CBR cycles. `init_ready` rises after the last one.
- R5: Every CBR cycle has this shape. `mem_cas_n` is low for CAS_LEAD_CYC cycles before `mem_ras_n` falls. `mem_ras_n` stays low for RAS_ACT_CYC cycles. Both strobes rise together and then remain high for at least RAS_PRE_CYC cycles.
- R6: In normal operation with the grant given promptly, `rfsh_req` rises once every INTERVAL_CYC cycles and each request yields one CBR cycle. The first request comes INTERVAL_CYC cycles after `init_ready` rises.
- R7: Intervals that expire while the grant is withheld accumulate, up to MAX_PENDING. When the grant arrives, that many CBR cycles run back to back, after which `rfsh_req` drops and `init_ready` stays high.
- R8: If an interval expires while MAX_PENDING refreshes are already outstanding, `init_ready` falls and `refresh_miss` rises on the next edge. The WAKE_CNT burst is then run again. At the end of that burst `refresh_miss` clears and `init_ready` returns high.
- R9: `init_ready` is low throughout the pause and every wake-up burst, and it is never high together with `refresh_miss`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rfsh_gnt | input | 1 | Strobe bus granted to the sequencer by the access controller |
| rfsh_req | output | 1 | Sequencer needs, or is using, the strobe bus |
| mem_ras_n | output | 1 | Row strobe, active low, driven during refresh |
| mem_cas_n | output | 1 | Column strobe, active low, driven during refresh |
| init_ready | output | 1 | Power-up and wake-up complete; memory may be accessed |
| refresh_miss | output | 1 | Retention deadline broken; recovery burst in progress |

## Verification
The bench builds the block with a 20-cycle pause, a 40-cycle refresh interval, a postpone limit of 2, eight wake-up cycles, and a strobe shape of 1 lead, 3 active and 2 precharge cycles. These small values bring the full power-up, several periodic intervals, a two-deep catch-up after a withheld grant, and a deadline overflow with its recovery burst within a few hundred cycles. Each of these paths can then be timed to the exact edge. With the short CBR cycle, a back-to-back pair of refreshes fits well inside one interval, so the catch-up path can be separated from the overflow path.

// File: rtl/rfsh_seq_pkg.sv
// Shared state encodings for the DRAM refresh sequencer.
package rfsh_seq_pkg;

    // Top-level phase of the sequencer.
    typedef enum logic [1:0] {
        SEQ_PAUSE = 2'd0,
        SEQ_WAKE  = 2'd1,
        SEQ_RUN   = 2'd2
    } seq_state_e;

    // Phase of one CBR strobe cycle.
    typedef enum logic [1:0] {
        CBR_IDLE = 2'd0,
        CBR_LEAD = 2'd1,
        CBR_ACT  = 2'd2,
        CBR_PRE  = 2'd3
    } cbr_state_e;

endpackage

// File: rtl/rfsh_cycle_timer.sv
// Free-running cycle timer.
// Counts clock cycles while `run` is high and pulses `tick` in the last
// cycle of every LIMIT-cycle period. It clears to zero whenever `run` is low,
// so each enable starts a full period.
// Assumes LIMIT >= 1.
module rfsh_cycle_timer #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Advance the count while enabled and wrap at the end of the period.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

    assign tick = run && (cnt == LAST);

    // R6: the count never leaves its period
    a_r6_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/rfsh_cbr_engine.sv
// CBR strobe generator.
// On `start` (accepted only when idle), it drives one CAS-before-RAS cycle:
// CAS low for LEAD_CYC cycles, then RAS and CAS low for ACT_CYC cycles, then
// both high for PRE_CYC cycles. `done` is high in the last precharge cycle.
// Assumes every cycle count is at least 1 and that the grant stays with the
// sequencer for the whole cycle.
module rfsh_cbr_engine
    import rfsh_seq_pkg::*;
#(
    parameter int LEAD_CYC = 2,
    parameter int ACT_CYC  = 10,
    parameter int PRE_CYC  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic ras_n,
    output logic cas_n,
    output logic busy,
    output logic done
);
    localparam int MAX_A = (LEAD_CYC > ACT_CYC) ? LEAD_CYC : ACT_CYC;
    localparam int MAX_C = (MAX_A > PRE_CYC) ? MAX_A : PRE_CYC;
    localparam int CW    = $clog2(MAX_C + 1);

    cbr_state_e     state;
    logic [CW-1:0]  cnt;

    // Step through lead, active and precharge phases with one shared counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CBR_IDLE;
            cnt   <= '0;
        end else begin
            case (state)
                CBR_IDLE: if (start) begin
                    state <= CBR_LEAD;
                    cnt   <= CW'(LEAD_CYC - 1);
                end
                CBR_LEAD: if (cnt == '0) begin
                    state <= CBR_ACT;
                    cnt   <= CW'(ACT_CYC - 1);
                end else begin
                    cnt <= cnt - CW'(1);
                end
                CBR_ACT: if (cnt == '0) begin
                    state <= CBR_PRE;
                    cnt   <= CW'(PRE_CYC - 1);
                end else begin
                    cnt <= cnt - CW'(1);
                end
                default: if (cnt == '0) begin
                    state <= CBR_IDLE;
                end else begin
                    cnt <= cnt - CW'(1);
                end
            endcase
        end
    end

    // Decode the strobe levels and handshake flags from the phase.
    always_comb begin
        ras_n = (state != CBR_ACT);
        cas_n = !((state == CBR_LEAD) || (state == CBR_ACT));
        busy  = (state != CBR_IDLE);
        done  = (state == CBR_PRE) && (cnt == '0);
    end

    // R5: RAS only ever falls while CAS is already low
    a_r5_ras_falls_under_cas: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> !cas_n);

    // R5: CAS is released together with RAS
    a_r5_cas_rises_with_ras: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cas_n) |-> $rose(ras_n));

    // R5: a new cycle never starts out of precharge
    a_r5_precharge_kept: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(!busy));

endmodule

// File: rtl/dram_refresh_sequencer.sv
// DRAM refresh and power-up sequencer (top).
// The phases are pause, then wake-up burst, then periodic CBR refresh. On a
// deadline overflow it falls back to the wake-up burst.
// Uses a level request/grant handshake with the access controller.
// Assumes the controller keeps `rfsh_gnt` high while a CBR cycle is running.
// Default timing assumes a 200 MHz clock: a 200 us pause, one refresh per
// 15.6 us, a 50 ns RAS-active time and a 40 ns precharge.
module dram_refresh_sequencer
    import rfsh_seq_pkg::*;
#(
    parameter int PAUSE_CYC    = 40000,
    parameter int WAKE_CNT     = 8,
    parameter int INTERVAL_CYC = 3120,
    parameter int MAX_PENDING  = 8,
    parameter int CAS_LEAD_CYC = 2,
    parameter int RAS_ACT_CYC  = 10,
    parameter int RAS_PRE_CYC  = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rfsh_gnt,
    output logic rfsh_req,
    output logic mem_ras_n,
    output logic mem_cas_n,
    output logic init_ready,
    output logic refresh_miss
);
    localparam int WAKE_W = $clog2(WAKE_CNT + 1);
    localparam int PEND_W = $clog2(MAX_PENDING + 1);
    localparam logic [PEND_W-1:0] PEND_MAX = PEND_W'(MAX_PENDING);

    seq_state_e         state;
    logic [WAKE_W-1:0]  wake_left;
    logic [PEND_W-1:0]  pending;
    logic               miss_q;
    logic               pause_tick;
    logic               ival_tick;
    logic               need;
    logic               start;
    logic               busy;
    logic               done;
    logic               overflow;

    rfsh_cycle_timer #(.LIMIT(PAUSE_CYC)) i_pause_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == SEQ_PAUSE),
        .tick  (pause_tick)
    );

    rfsh_cycle_timer #(.LIMIT(INTERVAL_CYC)) i_interval_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state == SEQ_RUN),
        .tick  (ival_tick)
    );

    rfsh_cbr_engine #(
        .LEAD_CYC (CAS_LEAD_CYC),
        .ACT_CYC  (RAS_ACT_CYC),
        .PRE_CYC  (RAS_PRE_CYC)
    ) i_cbr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .ras_n (mem_ras_n),
        .cas_n (mem_cas_n),
        .busy  (busy),
        .done  (done)
    );

    // Decide whether a refresh is owed and when the engine may start.
    always_comb begin
        case (state)
            SEQ_WAKE: need = (wake_left != '0);
            SEQ_RUN:  need = (pending != '0);
            default:  need = 1'b0;
        endcase
        start    = rfsh_gnt && need && !busy;
        overflow = (state == SEQ_RUN) && ival_tick && !done && (pending == PEND_MAX);
    end

    // Phase sequencing, wake-up burst count and postponed-refresh count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_PAUSE;
            wake_left <= '0;
            pending   <= '0;
            miss_q    <= 1'b0;
        end else begin
            case (state)
                SEQ_PAUSE: if (pause_tick) begin
                    state     <= SEQ_WAKE;
                    wake_left <= WAKE_W'(WAKE_CNT);
                end
                SEQ_WAKE: if (done && wake_left != '0) begin
                    if (wake_left == WAKE_W'(1)) begin
                        state  <= SEQ_RUN;
                        miss_q <= 1'b0;
                    end
                    wake_left <= wake_left - WAKE_W'(1);
                end
                default: begin
                    if (overflow) begin
                        state     <= SEQ_WAKE;
                        wake_left <= WAKE_W'(WAKE_CNT);
                        pending   <= '0;
                        miss_q    <= 1'b1;
                    end else if (ival_tick && !done) begin
                        pending <= pending + PEND_W'(1);
                    end else if (done && !ival_tick && pending != '0) begin
                        pending <= pending - PEND_W'(1);
                    end
                end
            endcase
        end
    end

    // Drive the handshake and status outputs.
    always_comb begin
        rfsh_req     = need || busy;
        init_ready   = (state == SEQ_RUN);
        refresh_miss = miss_q;
    end

    // R2: nothing is requested or strobed during the power-up pause
    a_r2_quiet_pause: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SEQ_PAUSE) |-> (!rfsh_req && mem_ras_n && mem_cas_n));

    // R3: an ungranted idle request is held
    a_r3_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_req && !rfsh_gnt && !busy) |=> rfsh_req);

    // R3: a strobe cycle only begins under grant
    a_r3_strobe_granted: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_cas_n) |-> $past(rfsh_gnt));

    // R7: postponed refreshes never exceed the limit
    a_r7_pending_bound: assert property (@(posedge clk) disable iff (!rst_n)
        pending <= PEND_MAX);

    // R8: a broken deadline takes the ready output down
    a_r8_miss_drops_ready: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(refresh_miss) |-> !init_ready);

    // R9: ready and miss are never high together
    a_r9_ready_excl_miss: assert property (@(posedge clk) disable iff (!rst_n)
        init_ready |-> !refresh_miss);

endmodule

// File: tb/test_dram_refresh_sequencer.sv
`timescale 1ns/100ps
module test_dram_refresh_sequencer;
    localparam int PAUSE   = 20;
    localparam int WAKE    = 8;
    localparam int IVAL    = 40;
    localparam int MAXP    = 2;
    localparam int LEAD    = 1;
    localparam int ACT     = 3;
    localparam int PRE     = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0;
    logic req, ras_n, cas_n, ready, miss;

    int checks = 0;
    int fails  = 0;
    int falls  = 0;
    int ras_low_run = 0;
    int ras_high_run = 100;
    int cas_low_run = 0;
    logic prev_ras = 1'b1;

    always #2.5 clk = ~clk;

    dram_refresh_sequencer #(
        .PAUSE_CYC(PAUSE), .WAKE_CNT(WAKE), .INTERVAL_CYC(IVAL),
        .MAX_PENDING(MAXP), .CAS_LEAD_CYC(LEAD), .RAS_ACT_CYC(ACT),
        .RAS_PRE_CYC(PRE)
    ) i_dram_refresh_sequencer (
        .clk(clk), .rst_n(rst_n), .rfsh_gnt(gnt), .rfsh_req(req),
        .mem_ras_n(ras_n), .mem_cas_n(cas_n), .init_ready(ready),
        .refresh_miss(miss)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Strobe-shape monitor, sampling at the falling clock edge (R5).
    always @(negedge clk) begin
        if (rst_n) begin
            if (!ras_n && prev_ras) begin
                falls++;
                chk("R5 cas lead before ras fall", cas_low_run + (cas_n ? 0 : 1), LEAD + 1);
                chk("R5 precharge at least PRE", int'(ras_high_run >= PRE), 1);
            end
            if (ras_n && !prev_ras) begin
                chk("R5 ras active width", ras_low_run, ACT);
                chk("R5 cas released with ras", int'(cas_n), 1);
            end
            ras_low_run  = ras_n ? 0 : ras_low_run + 1;
            ras_high_run = ras_n ? ((ras_high_run > 1000) ? ras_high_run : ras_high_run + 1) : 0;
            cas_low_run  = cas_n ? 0 : cas_low_run + 1;
            if (!ras_n && prev_ras) cas_low_run = cas_low_run; // keep run for next phase
            prev_ras = ras_n;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_req_level(input logic lvl, input int limit, output int n);
        n = 0;
        while (req !== lvl && n < limit) begin
            step();
            n++;
        end
    endtask

    task automatic t_reset();
        step();
        chk("R1 ready after reset", int'(ready), 0);
        chk("R1 req after reset", int'(req), 0);
        chk("R1 ras_n after reset", int'(ras_n), 1);
        chk("R1 cas_n after reset", int'(cas_n), 1);
        rst_n = 1'b1;
    endtask

    task automatic t_pause();
        int n = 0;
        int moved = 0;
        while (!req && n < 200) begin
            step();
            n++;
            if (!ras_n || !cas_n) moved++;
        end
        chk("R2 edges until first request", n, PAUSE);
        chk("R2 strobes idle in pause", moved, 0);
        chk("R9 ready low after pause", int'(ready), 0);
    endtask

    task automatic t_withheld();
        int bad = 0;
        for (int i = 0; i < 10; i++) begin
            step();
            if (!req || !ras_n || !cas_n || ready) bad++;
        end
        chk("R3 request held, strobes idle without grant", bad, 0);
    endtask

    task automatic t_wake(input string tag);
        int f0 = falls;
        int n = 0;
        int rdy_early = 0;
        gnt = 1'b1;
        while (!ready && n < 400) begin
            step();
            n++;
        end
        chk({tag, " wake burst length"}, falls - f0, WAKE);
        chk({tag, " ready after burst"}, int'(ready), 1);
        chk({tag, " miss clear after burst"}, int'(miss), 0);
        chk("R9 ready excludes miss", int'(ready && miss), 0);
        if (rdy_early != 0) chk("R9 ready early", rdy_early, 0);
    endtask

    task automatic t_periodic();
        int n;
        int m;
        int f0;
        wait_req_level(1'b1, 200, n);
        chk("R6 first request after ready", n, IVAL);
        f0 = falls;
        wait_req_level(1'b0, 200, m);
        n = m;
        wait_req_level(1'b1, 200, m);
        n += m;
        chk("R6 request spacing", n, IVAL);
        chk("R6 one cbr per request", falls - f0, 1);
        chk("R6 ready held", int'(ready), 1);
    endtask

    task automatic t_catchup();
        int n;
        int f0;
        int bad = 0;
        wait_req_level(1'b0, 200, n);
        gnt = 1'b0;
        wait_req_level(1'b1, 200, n);
        f0 = falls;
        for (int i = 0; i < 45; i++) begin
            step();
            if (!req) bad++;
        end
        chk("R7 request held while postponed", bad, 0);
        chk("R7 no strobes while postponed", falls - f0, 0);
        gnt = 1'b1;
        wait_req_level(1'b0, 200, n);
        chk("R7 postponed refreshes served", falls - f0, MAXP);
        chk("R7 ready held after catch-up", int'(ready), 1);
        chk("R7 no miss after catch-up", int'(miss), 0);
    endtask

    task automatic t_overflow();
        int n;
        wait_req_level(1'b1, 200, n);
        wait_req_level(1'b0, 200, n);
        gnt = 1'b0;
        wait_req_level(1'b1, 200, n);
        repeat (2 * IVAL - 2) step();
        chk("R8 ready before overflow", int'(ready), 1);
        chk("R8 miss before overflow", int'(miss), 0);
        repeat (4) step();
        chk("R8 ready dropped on overflow", int'(ready), 0);
        chk("R8 miss raised on overflow", int'(miss), 1);
        chk("R8 request for recovery", int'(req), 1);
        t_wake("R8 recovery");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_pause();
        t_withheld();
        t_wake("R4");
        t_periodic();
        t_catchup();
        t_overflow();
        repeat (5) step();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule